// File: doc/BRIEF.md
# Dual-Channel Output Compare Timer with Linked Buffering

This block is a timebase plus two compare channels. A free-running up-counter counts from zero to a programmable modulus and wraps. Each channel holds a 16-bit compare value and a small control field. When the counter equals a channel's compare value, the channel pin is set, cleared, toggled or left alone, and the channel's interrupt flag is raised if that channel has interrupts enabled. A sticky overflow flag marks every wrap.

The two channels can be joined into one buffered channel that drives only the channel 0 pin. Software then writes the next compare value into whichever register set is idle. The set written last takes control at the next counter wrap, so the output never sees a half-finished period. While the channels are joined, the channel 1 pin is a general-purpose output driven from a one-bit data register.

Configuration goes through a plain write strobe with a 4-bit address and an 8-bit data byte. Every write is accepted in the cycle it is presented; there is no back-pressure. Wide values are written high byte first, then low byte.

Top module: `obc_timer`

## Requirements
- R1: While reset is held, `count` is 0, both pins are low, both compare flags and the overflow flag are 0, the link is off and register set 0 is the active one.
- R2: `count` rises by one each clock. In a cycle where `count` is at or above the modulus (address 0 = high byte, staged; address 1 = low byte, commits both), the next value is 0 and `ovf_flag` becomes 1. `ovf_flag` stays 1 until a write of bit 0 = 1 to address 8.
- R3: A compare match (`count` equals the value in a channel's register set) changes that channel's pin on the following clock edge. The action is bits [1:0] of the channel control register (address 6 for channel 0, 7 for channel 1): 00 none, 01 toggle, 10 clear, 11 set.
- R4: A match raises the channel's compare flag (`cmp_flag[0]` or `cmp_flag[1]`) only when bit 2 of its control register is 1. A write to address 8 with bit 1 (channel 0) or bit 2 (channel 1) set clears the flag. A match in the same cycle as the clear leaves the flag at 1.
- R5: With the channels unlinked, a completed compare write takes effect from the next cycle. A new value that the counter has already passed in the current period produces no match until the next period, even if the old value is still ahead.
- R6: Writing the high byte of a compare value (address 2 for channel 0, 4 for channel 1) inhibits that register set's compare until its low byte (address 3 or 5) is written. The low-byte write commits both bytes and re-enables the compare.
- R7: Writing 1 to bit 3 of the channel 0 control register links the channels. Register set 0 controls the channel 0 pin first. A completed write to register set 1 hands control to set 1 at the next counter wrap, not before.
- R8: While linked, at every counter wrap the active register set becomes the set whose low byte was written most recently. A write that completes in the wrap cycle itself counts.
- R9: While linked, the channel 0 control register governs the linked channel, the channel 1 control register has no effect, and `cmp_flag[1]` is never raised. `ch1_pin` follows bit 0 of the data register at address 9.
- R10: While linked, a write to the currently active register set takes effect from the next cycle, as in the unlinked case.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per asserted cycle |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Write data byte |
| count | output | 16 | Current counter value |
| ch0_pin | output | 1 | Channel 0 pin; also the linked channel's output |
| ch1_pin | output | 1 | Channel 1 pin, or the general-purpose data bit while linked |
| cmp_flag | output | 2 | Sticky compare flags, bit i for channel i |
| ovf_flag | output | 1 | Sticky counter overflow flag |

## Verification
A compare match and a software clear of the same compare flag can fall in one cycle. The bench waits until the counter shows the compare value and presents the clear write on that very cycle. It then expects the flag to read 1 in the next cycle and 0 after a second clear issued away from any match. The same approach, a write landing on the edge that also does other work, is used for the linked handover: register writes are timed against the counter so that the wrap edge decides which register set drives the pin in the following period.

// File: rtl/obc_pkg.sv
package obc_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_MOD_HI  = 4'd0;
  localparam logic [ADDR_W-1:0] A_MOD_LO  = 4'd1;
  localparam logic [ADDR_W-1:0] A_CMP0_HI = 4'd2;
  localparam logic [ADDR_W-1:0] A_CMP0_LO = 4'd3;
  localparam logic [ADDR_W-1:0] A_CMP1_HI = 4'd4;
  localparam logic [ADDR_W-1:0] A_CMP1_LO = 4'd5;
  localparam logic [ADDR_W-1:0] A_CTL0    = 4'd6;
  localparam logic [ADDR_W-1:0] A_CTL1    = 4'd7;
  localparam logic [ADDR_W-1:0] A_CLR     = 4'd8;
  localparam logic [ADDR_W-1:0] A_GPIO    = 4'd9;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } pin_act_e;

  typedef struct packed {
    logic     irq_en;
    pin_act_e act;
  } ch_ctl_t;

  function automatic logic next_pin(input pin_act_e a, input logic cur);
    case (a)
      ACT_TOGGLE: next_pin = ~cur;
      ACT_CLEAR:  next_pin = 1'b0;
      ACT_SET:    next_pin = 1'b1;
      default:    next_pin = cur;
    endcase
  endfunction

endpackage

// File: rtl/obc_counter.sv
module obc_counter
  import obc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] data,
  output logic [CW-1:0]     count_o,
  output logic [CW-1:0]     mod_o,
  output logic              wrap_o
);
  localparam int HW = CW - BYTE_W;

  logic [HW-1:0] mod_hi_q;
  logic [CW-1:0] mod_q;
  logic [CW-1:0] cnt_q;

  // the modulus is staged like a compare value so it never holds a mixed value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_hi_q <= '1;
      mod_q    <= '1;
    end else begin
      if (wr_hi) mod_hi_q <= data[HW-1:0];
      if (wr_lo) mod_q    <= {mod_hi_q, data};
    end
  end

  assign wrap_o = (cnt_q >= mod_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;
  assign mod_o   = mod_q;

endmodule

// File: rtl/obc_cmp_bank.sv
module obc_cmp_bank
  import obc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] data,
  output logic [CW-1:0]     val_o,
  output logic              inh_o,
  output logic              done_o
);
  localparam int HW = CW - BYTE_W;

  logic [HW-1:0] hi_q;
  logic [CW-1:0] val_q;
  logic          inh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '1;
      val_q <= '1;
      inh_q <= 1'b0;
    end else begin
      if (wr_hi) begin
        hi_q  <= data[HW-1:0];
        inh_q <= 1'b1;
      end
      if (wr_lo) begin
        val_q <= {hi_q, data};
        inh_q <= 1'b0;
      end
    end
  end

  assign val_o  = val_q;
  assign inh_o  = inh_q;
  assign done_o = wr_lo;

endmodule

// File: rtl/obc_route.sv
module obc_route
  import obc_pkg::*;
#(
  parameter int CW = 16,
  parameter int NCH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CW-1:0]           count,
  input  logic                    wrap,
  input  logic [NCH-1:0][CW-1:0]  val,
  input  logic [NCH-1:0]          inh,
  input  logic [NCH-1:0]          done,
  input  logic                    link,
  input  logic                    link_rise,
  input  ch_ctl_t                 ctl0,
  input  ch_ctl_t                 ctl1,
  output logic [NCH-1:0]          hit,
  output logic                    act_sel,
  output logic                    pin0,
  output logic                    pin1
);
  logic [NCH-1:0] solo_match;
  logic           act_q, last_q, last_nx;
  logic           linked_match;
  logic           pin0_q, pin1_q;

  for (genvar i = 0; i < NCH; i++) begin : g_match
    assign solo_match[i] = !inh[i] && (count == val[i]);
  end

  assign linked_match = !inh[act_q] && (count == val[act_q]);

  assign hit[0] = link ? linked_match : solo_match[0];
  assign hit[1] = !link && solo_match[1];

  // most recently completed write decides the next owner
  always_comb begin
    last_nx = last_q;
    if (done[1])      last_nx = 1'b1;
    else if (done[0]) last_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      last_q <= 1'b0;
    end else if (link_rise) begin
      act_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      last_q <= last_nx;
      if (link && wrap) act_q <= last_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin0_q <= 1'b0;
      pin1_q <= 1'b0;
    end else begin
      if (hit[0]) pin0_q <= next_pin(ctl0.act, pin0_q);
      if (hit[1]) pin1_q <= next_pin(ctl1.act, pin1_q);
    end
  end

  assign act_sel = act_q;
  assign pin0    = pin0_q;
  assign pin1    = pin1_q;

endmodule

// File: rtl/obc_timer.sv
module obc_timer
  import obc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CW-1:0]     count,
  output logic              ch0_pin,
  output logic              ch1_pin,
  output logic [1:0]        cmp_flag,
  output logic              ovf_flag
);
  localparam int NCH = 2;

  logic [CW-1:0]          mod_val;
  logic                   wrap;
  logic [NCH-1:0][CW-1:0] val;
  logic [NCH-1:0]         inh, done, hit;
  logic [NCH-1:0]         wr_hi_sel, wr_lo_sel;
  logic                   act_sel, pin0_raw, pin1_raw;
  ch_ctl_t                ctl0_q, ctl1_q;
  logic                   link_q, gpio_q, ovf_q;
  logic [1:0]             flag_q;
  logic                   clr_wr, link_rise;

  obc_counter #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hi   (wr_en && wr_addr == A_MOD_HI),
    .wr_lo   (wr_en && wr_addr == A_MOD_LO),
    .data    (wr_data),
    .count_o (count),
    .mod_o   (mod_val),
    .wrap_o  (wrap)
  );

  assign wr_hi_sel[0] = wr_en && wr_addr == A_CMP0_HI;
  assign wr_lo_sel[0] = wr_en && wr_addr == A_CMP0_LO;
  assign wr_hi_sel[1] = wr_en && wr_addr == A_CMP1_HI;
  assign wr_lo_sel[1] = wr_en && wr_addr == A_CMP1_LO;

  for (genvar i = 0; i < NCH; i++) begin : g_bank
    obc_cmp_bank #(.CW(CW)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hi  (wr_hi_sel[i]),
      .wr_lo  (wr_lo_sel[i]),
      .data   (wr_data),
      .val_o  (val[i]),
      .inh_o  (inh[i]),
      .done_o (done[i])
    );
  end

  assign link_rise = wr_en && wr_addr == A_CTL0 && wr_data[3] && !link_q;
  assign clr_wr    = wr_en && wr_addr == A_CLR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl0_q <= '0;
      ctl1_q <= '0;
      link_q <= 1'b0;
      gpio_q <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTL0: begin
          ctl0_q <= ch_ctl_t'(wr_data[2:0]);
          link_q <= wr_data[3];
        end
        A_CTL1: ctl1_q <= ch_ctl_t'(wr_data[2:0]);
        A_GPIO: gpio_q <= wr_data[0];
        default: ;
      endcase
    end
  end

  obc_route #(.CW(CW), .NCH(NCH)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (count),
    .wrap      (wrap),
    .val       (val),
    .inh       (inh),
    .done      (done),
    .link      (link_q),
    .link_rise (link_rise),
    .ctl0      (ctl0_q),
    .ctl1      (ctl1_q),
    .hit       (hit),
    .act_sel   (act_sel),
    .pin0      (pin0_raw),
    .pin1      (pin1_raw)
  );

  // a new event beats a clear requested in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      flag_q <= '0;
    end else begin
      ovf_q     <= wrap | (ovf_q & ~(clr_wr & wr_data[0]));
      flag_q[0] <= (hit[0] & ctl0_q.irq_en) | (flag_q[0] & ~(clr_wr & wr_data[1]));
      flag_q[1] <= (hit[1] & ctl1_q.irq_en) | (flag_q[1] & ~(clr_wr & wr_data[2]));
    end
  end

  assign ch0_pin  = pin0_raw;
  assign ch1_pin  = link_q ? gpio_q : pin1_raw;
  assign cmp_flag = flag_q;
  assign ovf_flag = ovf_q;

endmodule

// File: rtl/obc_timer_chk.sv
module obc_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] count,
  input logic [CW-1:0] mod_q,
  input logic          ovf_flag,
  input logic [1:0]    cmp_flag,
  input logic          ch0_pin,
  input logic          link_q,
  input logic          inh0,
  input logic          act_sel
);

  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (count >= mod_q) |=> (count == '0));

  a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (count < mod_q) |=> (count == $past(count) + 1'b1));

  a_r2_ovf_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (count >= mod_q) |=> ovf_flag);

  a_r6_inhibit_holds_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_q && inh0) |=> $stable(ch0_pin));

  a_r8_owner_moves_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (link_q && count < mod_q) |=> $stable(act_sel));

  a_r9_no_ch1_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (link_q && !cmp_flag[1]) |=> !cmp_flag[1]);

endmodule

bind obc_timer obc_timer_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .count    (count),
  .mod_q    (mod_val),
  .ovf_flag (ovf_flag),
  .cmp_flag (cmp_flag),
  .ch0_pin  (ch0_pin),
  .link_q   (link_q),
  .inh0     (inh[0]),
  .act_sel  (act_sel)
);

// File: tb/obc_timer_test.sv
module obc_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] count;
  logic        ch0_pin, ch1_pin, ovf_flag;
  logic [1:0]  cmp_flag;

  int checks = 0;
  int bad = 0;

  always #10 clk = ~clk;

  obc_timer uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .count    (count),
    .ch0_pin  (ch0_pin),
    .ch1_pin  (ch1_pin),
    .cmp_flag (cmp_flag),
    .ovf_flag (ovf_flag)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] a_hi, input logic [15:0] v);
    wr(a_hi, v[15:8]);
    wr(a_hi + 4'd1, v[7:0]);
  endtask

  task automatic wait_count(input int v);
    int n = 0;
    while (count != v && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 2000) check_eq("wait timeout", int'(count), v);
  endtask

  task automatic toggle_at(input int v, input int exp_tog, input string tag);
    logic p;
    wait_count(v);
    p = ch0_pin;
    @(negedge clk);
    check_eq(tag, int'(ch0_pin), int'(p ^ exp_tog[0]));
  endtask

  task automatic t_reset;
    check_eq("R1 count", int'(count), 0);
    check_eq("R1 ch0_pin", int'(ch0_pin), 0);
    check_eq("R1 ch1_pin", int'(ch1_pin), 0);
    check_eq("R1 flags", int'({cmp_flag, ovf_flag}), 0);
  endtask

  task automatic t_counter;
    wr16(4'd0, 16'd99);
    wait_count(99);
    check_eq("R2 no overflow yet", int'(ovf_flag), 0);
    @(negedge clk);
    check_eq("R2 wrap to zero", int'(count), 0);
    check_eq("R2 overflow raised", int'(ovf_flag), 1);
    wr(4'd8, 8'h01);
    check_eq("R2 overflow cleared", int'(ovf_flag), 0);
  endtask

  task automatic t_actions;
    wr16(4'd2, 16'd40);
    wr(4'd6, 8'h05);
    toggle_at(40, 1, "R3 toggle");
    check_eq("R4 flag on match", int'(cmp_flag[0]), 1);
    wr(4'd8, 8'h02);
    check_eq("R4 flag cleared", int'(cmp_flag[0]), 0);
    wr(4'd6, 8'h06);
    wait_count(40); @(negedge clk);
    check_eq("R3 clear", int'(ch0_pin), 0);
    wr(4'd6, 8'h07);
    wait_count(40); @(negedge clk);
    check_eq("R3 set", int'(ch0_pin), 1);
    wr(4'd8, 8'h02);
    wr(4'd6, 8'h04);
    wait_count(40); @(negedge clk);
    check_eq("R3 none keeps pin", int'(ch0_pin), 1);
    check_eq("R4 flag with no action", int'(cmp_flag[0]), 1);
    wr(4'd8, 8'h02);
    wr(4'd6, 8'h02);
    wait_count(40); @(negedge clk);
    check_eq("R3 clear again", int'(ch0_pin), 0);
    check_eq("R4 no flag when disabled", int'(cmp_flag[0]), 0);
  endtask

  task automatic t_unbuffered;
    logic p;
    wr(4'd6, 8'h01);
    wr16(4'd2, 16'd60);
    toggle_at(60, 1, "R5 immediate effect");
    wait_count(50);
    wr16(4'd2, 16'd30);
    p = ch0_pin;
    wait_count(99);
    check_eq("R5 passed value missed", int'(ch0_pin), int'(p));
    toggle_at(30, 1, "R5 match next period");
    wr16(4'd2, 16'd70);
    toggle_at(70, 1, "R5 larger value same period");
    wait_count(10);
    wr(4'd2, 8'h00);
    p = ch0_pin;
    wait_count(99);
    wait_count(75);
    check_eq("R6 inhibited after high byte", int'(ch0_pin), int'(p));
    wr(4'd3, 8'd70);
    toggle_at(70, 1, "R6 low byte releases");
  endtask

  task automatic t_linked;
    wr16(4'd2, 16'd20);
    wr(4'd7, 8'h07);
    wr(4'd6, 8'h0D);
    wr(4'd9, 8'h01);
    check_eq("R9 gpio high", int'(ch1_pin), 1);
    wr(4'd9, 8'h00);
    check_eq("R9 gpio low", int'(ch1_pin), 0);
    toggle_at(20, 1, "R7 set 0 controls first");
    wait_count(30);
    wr16(4'd4, 16'd70);
    toggle_at(70, 0, "R7 no handover before wrap");
    toggle_at(20, 0, "R7 set 0 retired");
    toggle_at(70, 1, "R7 set 1 in control");
    check_eq("R9 no ch1 flag", int'(cmp_flag[1]), 0);
    check_eq("R9 ch1 pin from gpio", int'(ch1_pin), 0);
    wait_count(75);
    wr16(4'd2, 16'd50);
    toggle_at(50, 1, "R8 last written set 0 back");
    toggle_at(70, 0, "R8 set 1 retired");
    wr16(4'd2, 16'd90);
    toggle_at(90, 1, "R10 active set rewrite");
  endtask

  task automatic t_unlinked_ch1;
    wr(4'd6, 8'h05);
    wait_count(70); @(negedge clk);
    check_eq("R3 ch1 set action", int'(ch1_pin), 1);
    check_eq("R4 ch1 flag", int'(cmp_flag[1]), 1);
  endtask

  task automatic t_collision;
    wr(4'd8, 8'h07);
    check_eq("R4 flags cleared", int'(cmp_flag), 0);
    wait_count(90);
    wr(4'd8, 8'h02);
    check_eq("R4 match beats clear", int'(cmp_flag[0]), 1);
    wr(4'd8, 8'h02);
    check_eq("R4 later clear works", int'(cmp_flag[0]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_counter();
    t_actions();
    t_unbuffered();
    t_linked();
    t_unlinked_ch1();
    t_collision();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule